// File: doc/BRIEF.md
# Fixed-Point State-Variable Filter Core

This block is the integrating heart of a two-integrator-loop resonant filter, done entirely in signed integer arithmetic. It keeps three state registers (high-pass, band-pass and low-pass) and moves them forward in time when asked. Each request carries the summed filter input, an angular cutoff coefficient that has already been computed, and a 4-bit resonance setting. A request can ask for one elapsed sample cycle, which completes in a single clock. It can instead ask for many elapsed cycles, which the core works through in chunks of up to eight, one chunk per clock.

Requests use a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. All request fields are sampled on that edge. The source may change them freely afterwards. `req_ready` is low while a multi-cycle request is in progress, while the enable is low, and during reset. A request offered at those times is simply not taken, so the source keeps `req_valid` asserted until it sees ready. Completion is reported by a one-cycle `res_valid` pulse. That pulse has no ready: the three state outputs stay constant until the next accepted request, so a consumer can read them at any time after the pulse.

Top module: `svf_core`

## Requirements
- R1: A single-cycle request (`req_multi`=0) performs one update on its accept edge, in this order. First, dB = (c·HP)>>>20 and dL = (c·BP)>>>20, both taken from the states held before the edge. Then BP' = BP−dB and LP' = LP−dL. Last, HP' = ((BP'·q)>>>10) − LP' − vi. All shifts are arithmetic and all products are exact. Results wrap to the state width.
- R2: The damping multiplier q is trunc(1024/(0.707 + res/15)) for the 4-bit resonance res. This runs from 1448 at res=0 down to 599 at res=15.
- R3: In a single-cycle update, c = min(w0, 105414), which caps the cutoff at 16 kHz.
- R4: In a multi-cycle request, each chunk of k cycles uses c = (min(w0, 26353)·k)>>6 with shift 14 in place of 20 (cap 4 kHz). The update order is the same as in R1.
- R5: A multi-cycle request for N>0 cycles is applied as chunks of min(8, remaining), one chunk per clock after the accept edge. `busy` is high for exactly ceil(N/8) cycles.
- R6: `res_valid` is high for one cycle. It rises on the edge that applies the final update: the accept edge for a single-cycle request, the last chunk edge for a multi-cycle one. A multi-cycle request with N=0 pulses `res_valid` after its accept edge and leaves the states unchanged.
- R7: `req_ready` is low while `busy` is high. A request offered then is not taken and has no effect on the results.
- R8: When `enable` is low, HP, BP and LP are zero after the next edge. `busy` also clears and `req_ready` goes low. An interrupted multi-cycle request produces no `res_valid`.
- R9: A synchronous reset clears all three states, `busy` and `res_valid`.
- R10: vi, w0 and res are captured on the accept edge. Changing them on the pins while a multi-cycle request runs does not alter its chunks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Filter enable; low forces the states to zero |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Core can take a request |
| req_multi | input | 1 | 0 = one cycle, 1 = multi-cycle request |
| req_cycles | input | CNT_W (16) | Elapsed cycles for a multi-cycle request |
| req_vi | input | VI_W (16) | Signed filter input sum |
| req_w0 | input | W0_W (18) | Unsigned cutoff coefficient before capping |
| req_res | input | 4 | Resonance setting |
| res_valid | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Multi-cycle request in progress |
| hp_out | output | DATA_W (24) | Signed high-pass state |
| bp_out | output | DATA_W (24) | Signed band-pass state |
| lp_out | output | DATA_W (24) | Signed low-pass state |

## Verification
The three states feed back on one another. A wrong coefficient, shift, cap, damping entry or update order therefore shows up in the outputs at the very next `res_valid`. The error then grows over later requests rather than fading. A chunking fault is visible at once as a wrong number of `busy` cycles, or as an early or late `res_valid`. A fault in the enable or ready gating shows up within one or two cycles as non-zero states, a spurious completion, or a taken request whose effect corrupts the next scoreboard comparison.

// File: rtl/svf_pkg.sv
package svf_pkg;

  localparam int SHIFT_SINGLE = 20;
  localparam int SHIFT_CHUNK  = 14;
  localparam int Q_SHIFT      = 10;
  localparam int K_SHIFT      = 6;

  // trunc(2*pi*f*1.048576) for f = 16 kHz and 4 kHz
  localparam int CAP_SINGLE = 105414;
  localparam int CAP_CHUNK  = 26353;

  localparam int Q_W = 12;

  typedef enum logic {
    STEP_SINGLE = 1'b0,
    STEP_CHUNK  = 1'b1
  } step_mode_e;

  // trunc(1024 / (0.707 + r/15))
  function automatic logic [Q_W-1:0] qdiv_lut(input logic [3:0] r);
    logic [Q_W-1:0] v;
    case (r)
      4'd0:    v = 12'd1448;
      4'd1:    v = 12'd1323;
      4'd2:    v = 12'd1218;
      4'd3:    v = 12'd1128;
      4'd4:    v = 12'd1051;
      4'd5:    v = 12'd984;
      4'd6:    v = 12'd925;
      4'd7:    v = 12'd872;
      4'd8:    v = 12'd825;
      4'd9:    v = 12'd783;
      4'd10:   v = 12'd745;
      4'd11:   v = 12'd710;
      4'd12:   v = 12'd679;
      4'd13:   v = 12'd650;
      4'd14:   v = 12'd624;
      default: v = 12'd599;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/svf_coef.sv
module svf_coef
  import svf_pkg::*;
#(
  parameter int W0_W = 18,
  parameter int K_W  = 4
) (
  input  logic [W0_W-1:0] w0,
  input  step_mode_e      mode,
  input  logic [K_W-1:0]  k,
  output logic [W0_W-1:0] coef
);

  localparam int WK_W = W0_W + K_W;
  localparam logic [W0_W-1:0] CAP1 = W0_W'(CAP_SINGLE);
  localparam logic [W0_W-1:0] CAP4 = W0_W'(CAP_CHUNK);

  logic [W0_W-1:0] w_single;
  logic [W0_W-1:0] w_chunk;
  logic [WK_W-1:0] wk_full;

  always_comb begin
    w_single = (w0 > CAP1) ? CAP1 : w0;
    w_chunk  = (w0 > CAP4) ? CAP4 : w0;
    wk_full  = WK_W'(w_chunk) * WK_W'(k);
    if (mode == STEP_CHUNK) coef = W0_W'(wk_full >> K_SHIFT);
    else                    coef = w_single;
  end

endmodule

// File: rtl/svf_step.sv
module svf_step
  import svf_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int VI_W   = 16,
  parameter int W0_W   = 18
) (
  input  logic signed [DATA_W-1:0] hp,
  input  logic signed [DATA_W-1:0] bp,
  input  logic signed [DATA_W-1:0] lp,
  input  logic        [W0_W-1:0]   coef,
  input  step_mode_e               mode,
  input  logic        [Q_W-1:0]    qdiv,
  input  logic signed [VI_W-1:0]   vi,
  output logic signed [DATA_W-1:0] hp_n,
  output logic signed [DATA_W-1:0] bp_n,
  output logic signed [DATA_W-1:0] lp_n
);

  localparam int PROD_W  = DATA_W + W0_W + 1;
  localparam int QPROD_W = DATA_W + Q_W + 1;

  logic signed [PROD_W-1:0]  coef_s;
  logic signed [PROD_W-1:0]  p_hp;
  logic signed [PROD_W-1:0]  p_bp;
  logic signed [PROD_W-1:0]  s_hp;
  logic signed [PROD_W-1:0]  s_bp;
  logic signed [DATA_W-1:0]  d_bp;
  logic signed [DATA_W-1:0]  d_lp;
  logic signed [QPROD_W-1:0] q_s;
  logic signed [QPROD_W-1:0] qp;
  logic signed [DATA_W-1:0]  q_term;

  always_comb begin
    // integrator increments, both from the pre-step states
    coef_s = $signed(PROD_W'(coef));
    p_hp   = coef_s * PROD_W'(hp);
    p_bp   = coef_s * PROD_W'(bp);
    if (mode == STEP_CHUNK) begin
      s_hp = p_hp >>> SHIFT_CHUNK;
      s_bp = p_bp >>> SHIFT_CHUNK;
    end else begin
      s_hp = p_hp >>> SHIFT_SINGLE;
      s_bp = p_bp >>> SHIFT_SINGLE;
    end
    d_bp = DATA_W'(s_hp);
    d_lp = DATA_W'(s_bp);
    bp_n = bp - d_bp;
    lp_n = lp - d_lp;
    // summer uses the freshly updated integrators
    q_s    = $signed(QPROD_W'(qdiv));
    qp     = QPROD_W'(bp_n) * q_s;
    q_term = DATA_W'(qp >>> Q_SHIFT);
    hp_n   = q_term - lp_n - DATA_W'(vi);
  end

endmodule

// File: rtl/svf_seq.sv
module svf_seq #(
  parameter int CNT_W     = 16,
  parameter int CHUNK_MAX = 8,
  parameter int K_W       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             req_valid,
  input  logic             req_multi,
  input  logic [CNT_W-1:0] req_cycles,
  output logic             req_ready,
  output logic             accept,
  output logic             step_fire,
  output logic             busy,
  output logic [K_W-1:0]   k,
  output logic             res_valid
);

  localparam logic [CNT_W-1:0] CMAX = CNT_W'(CHUNK_MAX);

  logic [CNT_W-1:0] rem;
  logic             last_chunk;

  assign req_ready  = enable && !busy;
  assign accept     = req_valid && req_ready;
  assign step_fire  = (accept && !req_multi) || busy;
  assign last_chunk = (rem <= CMAX);

  always_comb begin
    if (rem > CMAX) k = K_W'(CHUNK_MAX);
    else            k = rem[K_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      busy      <= 1'b0;
      rem       <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (accept) begin
        if (!req_multi || req_cycles == '0) begin
          res_valid <= 1'b1;
        end else begin
          busy <= 1'b1;
          rem  <= req_cycles;
        end
      end else if (busy) begin
        rem <= rem - CNT_W'(k);
        if (last_chunk) begin
          busy      <= 1'b0;
          res_valid <= 1'b1;
        end
      end
    end
  end

  assert_chunk_bound_R5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (k >= K_W'(1) && k <= K_W'(CHUNK_MAX)));

  assert_rem_shrinks_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (rem < $past(rem)));

  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready);

  assert_done_after_work_R6: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !busy);

endmodule

// File: rtl/svf_core.sv
module svf_core
  import svf_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int VI_W      = 16,
  parameter int W0_W      = 18,
  parameter int CNT_W     = 16,
  parameter int CHUNK_MAX = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     enable,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_multi,
  input  logic        [CNT_W-1:0]  req_cycles,
  input  logic signed [VI_W-1:0]   req_vi,
  input  logic        [W0_W-1:0]   req_w0,
  input  logic        [3:0]        req_res,
  output logic                     res_valid,
  output logic                     busy,
  output logic signed [DATA_W-1:0] hp_out,
  output logic signed [DATA_W-1:0] bp_out,
  output logic signed [DATA_W-1:0] lp_out
);

  localparam int K_W = $clog2(CHUNK_MAX + 1);
  localparam logic [W0_W-1:0] CAP1_V  = W0_W'(CAP_SINGLE);
  localparam logic [W0_W-1:0] CHUNK_V = W0_W'((CAP_CHUNK * CHUNK_MAX) >> K_SHIFT);

  logic                     accept;
  logic                     step_fire;
  logic [K_W-1:0]           k;
  logic signed [VI_W-1:0]   lat_vi;
  logic        [W0_W-1:0]   lat_w0;
  logic        [3:0]        lat_res;
  logic signed [VI_W-1:0]   vi_sel;
  logic        [W0_W-1:0]   w0_sel;
  logic        [3:0]        res_sel;
  logic        [Q_W-1:0]    qdiv;
  step_mode_e               mode;
  logic        [W0_W-1:0]   coef;
  logic signed [DATA_W-1:0] hp_q, bp_q, lp_q;
  logic signed [DATA_W-1:0] hp_n, bp_n, lp_n;

  svf_seq #(.CNT_W(CNT_W), .CHUNK_MAX(CHUNK_MAX), .K_W(K_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .req_valid  (req_valid),
    .req_multi  (req_multi),
    .req_cycles (req_cycles),
    .req_ready  (req_ready),
    .accept     (accept),
    .step_fire  (step_fire),
    .busy       (busy),
    .k          (k),
    .res_valid  (res_valid)
  );

  // request fields captured at the handshake for chunked work
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_vi  <= '0;
      lat_w0  <= '0;
      lat_res <= '0;
    end else if (accept) begin
      lat_vi  <= req_vi;
      lat_w0  <= req_w0;
      lat_res <= req_res;
    end
  end

  always_comb begin
    mode    = busy ? STEP_CHUNK : STEP_SINGLE;
    vi_sel  = busy ? lat_vi  : req_vi;
    w0_sel  = busy ? lat_w0  : req_w0;
    res_sel = busy ? lat_res : req_res;
    qdiv    = qdiv_lut(res_sel);
  end

  svf_coef #(.W0_W(W0_W), .K_W(K_W)) u_coef (
    .w0   (w0_sel),
    .mode (mode),
    .k    (k),
    .coef (coef)
  );

  svf_step #(.DATA_W(DATA_W), .VI_W(VI_W), .W0_W(W0_W)) u_step (
    .hp   (hp_q),
    .bp   (bp_q),
    .lp   (lp_q),
    .coef (coef),
    .mode (mode),
    .qdiv (qdiv),
    .vi   (vi_sel),
    .hp_n (hp_n),
    .bp_n (bp_n),
    .lp_n (lp_n)
  );

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      hp_q <= '0;
      bp_q <= '0;
      lp_q <= '0;
    end else if (step_fire) begin
      hp_q <= hp_n;
      bp_q <= bp_n;
      lp_q <= lp_n;
    end
  end

  assign hp_out = hp_q;
  assign bp_out = bp_q;
  assign lp_out = lp_q;

  assert_single_cap_R3: assert property (@(posedge clk) disable iff (rst)
    (step_fire && !busy) |-> (coef <= CAP1_V));

  assert_chunk_cap_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (coef <= CHUNK_V));

  assert_disabled_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (hp_q == '0 && bp_q == '0 && lp_q == '0));

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (enable && !step_fire) |=> (!enable || ($stable(hp_q) && $stable(bp_q) && $stable(lp_q))));

endmodule

// File: tb/svf_core_bench.sv
`timescale 1ns/100ps
module svf_core_bench;

  localparam int DATA_W = 24;
  localparam int VI_W   = 16;
  localparam int W0_W   = 18;
  localparam int CNT_W  = 16;
  localparam int XS     = 64 - DATA_W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                     rst, enable, req_valid, req_ready, req_multi;
  logic        [CNT_W-1:0]  req_cycles;
  logic signed [VI_W-1:0]   req_vi;
  logic        [W0_W-1:0]   req_w0;
  logic        [3:0]        req_res;
  logic                     res_valid, busy;
  logic signed [DATA_W-1:0] hp_out, bp_out, lp_out;

  svf_core u_svf_core (
    .clk(clk), .rst(rst), .enable(enable), .req_valid(req_valid),
    .req_ready(req_ready), .req_multi(req_multi), .req_cycles(req_cycles),
    .req_vi(req_vi), .req_w0(req_w0), .req_res(req_res),
    .res_valid(res_valid), .busy(busy),
    .hp_out(hp_out), .bp_out(bp_out), .lp_out(lp_out)
  );

  typedef struct {
    longint hp;
    longint bp;
    longint lp;
    string  tag;
  } exp_t;

  exp_t   sb[$];
  int     n_cmp = 0;
  int     n_bad = 0;
  longint m_hp = 0, m_bp = 0, m_lp = 0;
  longint cap16, cap4;
  bit     done_flag = 0;

  function automatic longint sx(longint v);
    return (v <<< XS) >>> XS;
  endfunction

  function automatic void check(bit ok, string tag, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endfunction

  function automatic void mstep(longint c, int sh, longint q, longint vi);
    longint dbp, dlp;
    dbp  = (c * m_hp) >>> sh;
    dlp  = (c * m_bp) >>> sh;
    m_bp = sx(m_bp - dbp);
    m_lp = sx(m_lp - dlp);
    m_hp = sx(((m_bp * q) >>> 10) - m_lp - vi);
  endfunction

  // monitor: pop and compare on every completion
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (sb.size() == 0) begin
        check(0, "R6", "completion with nothing outstanding", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(longint'(hp_out) == e.hp, e.tag, "hp", longint'(hp_out), e.hp);
        check(longint'(bp_out) == e.bp, e.tag, "bp", longint'(bp_out), e.bp);
        check(longint'(lp_out) == e.lp, e.tag, "lp", longint'(lp_out), e.lp);
      end
    end
  end

  task automatic do_req(bit multi, int cycles, int vi, int w0, int res, bit poke, string tag);
    longint q, c, wc;
    int     rem, kk, chunks, busy_n;
    bit     poked;
    exp_t   e;
    q = longint'($rtoi(1024.0 / (0.707 + real'(res) / 15.0)));
    while (!req_ready) @(negedge clk);
    req_valid  = 1'b1;
    req_multi  = multi;
    req_cycles = CNT_W'(cycles);
    req_vi     = VI_W'(vi);
    req_w0     = W0_W'(w0);
    req_res    = 4'(res);
    chunks     = 0;
    if (!multi) begin
      c = (w0 < cap16) ? w0 : cap16;
      mstep(c, 20, q, vi);
    end else begin
      rem = cycles;
      wc  = (w0 < cap4) ? w0 : cap4;
      while (rem > 0) begin
        kk = (rem > 8) ? 8 : rem;
        c  = (wc * kk) >>> 6;
        mstep(c, 14, q, vi);
        rem -= kk;
        chunks++;
      end
    end
    e.hp = m_hp; e.bp = m_bp; e.lp = m_lp; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    busy_n    = 0;
    poked     = 0;
    while (!res_valid) begin
      if (busy) busy_n++;
      if (poke && busy && !poked) begin
        // R7: offered request while busy must be refused; R10: pins move
        check(req_ready == 1'b0, "R7", "ready while busy", req_ready, 0);
        req_valid  = 1'b1;
        req_multi  = 1'b0;
        req_vi     = VI_W'(-7777);
        req_w0     = W0_W'(150000);
        req_res    = 4'd15;
        poked      = 1;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(busy_n == chunks, "R5", "busy cycles", busy_n, chunks);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      check(0, "WATCHDOG", "run finished", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cap16 = longint'($rtoi(2.0 * 3.141592653589793 * 16000.0 * 1.048576));
    cap4  = longint'($rtoi(2.0 * 3.141592653589793 * 4000.0 * 1.048576));
    rst = 1'b1; enable = 1'b1; req_valid = 1'b0; req_multi = 1'b0;
    req_cycles = '0; req_vi = '0; req_w0 = '0; req_res = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check(hp_out == 0 && bp_out == 0 && lp_out == 0, "R9", "states after reset", longint'(hp_out), 0);
    check(busy == 0 && res_valid == 0, "R9", "busy/res_valid after reset", busy, 0);
    check(req_ready == 1, "R9", "ready after reset", req_ready, 1);

    // R1: single steps
    do_req(0, 0, 4000, 8000, 0, 0, "R1");
    do_req(0, 0, 4000, 8000, 0, 0, "R1");
    do_req(0, 0, -2500, 60000, 3, 0, "R1");
    // R2: resonance extremes and middle
    do_req(0, 0, 3000, 40000, 15, 0, "R2");
    do_req(0, 0, 3000, 40000, 7, 0, "R2");
    do_req(0, 0, -3000, 40000, 11, 0, "R2");
    // R3: coefficient above the single-step cap
    do_req(0, 0, 5000, 250000, 4, 0, "R3");
    do_req(0, 0, 5000, 105415, 4, 0, "R3");
    // R4: chunked coefficient, below and above cap
    do_req(1, 1, 2000, 9000, 2, 0, "R4");
    do_req(1, 17, -4000, 200000, 9, 0, "R4");
    // R5: chunk boundaries
    do_req(1, 8, 1500, 20000, 5, 0, "R5");
    do_req(1, 9, 1500, 20000, 5, 0, "R5");
    do_req(1, 23, -1500, 26353, 13, 0, "R5");
    // R6: zero-length multi request
    do_req(1, 0, 7000, 20000, 1, 0, "R6");
    // R7/R10: request offered and pins changed while busy
    do_req(1, 40, 2500, 15000, 6, 1, "R10");
    // back-to-back random singles and multis
    for (int i = 0; i < 30; i++) begin
      int vi_r, w_r, r_r, n_r;
      vi_r = int'($urandom_range(16000)) - 8000;
      w_r  = int'($urandom_range(262143));
      r_r  = int'($urandom_range(15));
      n_r  = int'($urandom_range(30));
      do_req(i[0], n_r, vi_r, w_r, r_r, 0, "R1");
    end

    // R8: enable drop aborts a running multi request
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_multi = 1'b1; req_cycles = 16'd64;
    req_vi = 16'sd3000; req_w0 = 18'd20000; req_res = 4'd8;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(hp_out == 0 && bp_out == 0 && lp_out == 0, "R8", "states while disabled", longint'(bp_out), 0);
    check(busy == 0, "R8", "busy while disabled", busy, 0);
    check(req_ready == 0, "R8", "ready while disabled", req_ready, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(res_valid == 0, "R8", "completion after abort", res_valid, 0);
    end
    m_hp = 0; m_bp = 0; m_lp = 0;
    enable = 1'b1;
    @(negedge clk);
    do_req(0, 0, 6000, 30000, 10, 0, "R8");
    do_req(1, 12, -6000, 30000, 10, 0, "R8");

    // R9: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(hp_out == 0 && bp_out == 0 && lp_out == 0, "R9", "states after second reset", longint'(lp_out), 0);
    m_hp = 0; m_bp = 0; m_lp = 0;
    do_req(0, 0, 1000, 70000, 0, 0, "R9");

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R6", "outstanding expectations", sb.size(), 0);
    done_flag = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule